// File: doc/BRIEF.md
# Receive Interrupt Flag Controller

This block owns the receive-complete interrupt of a synchronous serial receiver. The receive datapath delivers a one-cycle strobe and a data byte when a character is complete, plus a one-cycle strobe for a master-side overrun. The block stores the byte in a receive buffer and keeps a sticky "character pending" flag. It also holds a receive interrupt-enable bit and a global interrupt-enable bit. From these it forms a registered interrupt request that is gated by a priority-valid input.

The pending flag has four ways to clear: a power-up clear, a held software-reset bit, a read of the receive buffer, and the processor's acknowledge that service has started. The acknowledge also forces the global enable low. No new request can then be raised until software sets the global enable again. While the request is gated off, a pending flag simply waits and is never dropped.

The power-up clear is the asynchronous active-low `rst_n`. It is released synchronously through a short synchronizer inside the block.

Top module: `rx_irq_flag_ctrl`

## Requirements
- R1: After power-up clear is released, the flag, receive enable, global enable and interrupt request all read 0, and the buffer reads 0.
- R2: With the software-reset bit at 0, a character strobe in cycle t loads `rx_data` into the buffer and sets the flag. Both `rd_data` and `flag` show the new state from cycle t+1.
- R3: A master-overrun strobe sets the flag only while `master_mode` is 1. Otherwise it has no effect on the flag. It never changes the buffer.
- R4: A buffer-read pulse with no set event in the same cycle clears the flag on the next cycle and leaves `rd_data` unchanged.
- R5: An interrupt acknowledge with no set event in the same cycle clears the flag on the next cycle. An acknowledge always forces the global enable to 0.
- R6: While the software-reset bit is 1, the flag and the receive enable are 0 on the next cycle. Character strobes, overrun strobes and enable writes are ignored, and the buffer keeps its value.
- R7: When a set event and a clear event (read or acknowledge) fall in the same cycle, the flag is 1 on the next cycle.
- R8: `irq_req` in cycle t+1 equals the AND of the next-cycle flag, receive enable and global enable with `prio_ok` sampled in cycle t. Because of this, `irq_req` is never 1 unless the flag and both enables are 1.
- R9: With no set, clear or software-reset event, the flag holds its value whatever the enables and `prio_ok` are.
- R10: The global enable is set by `gie_set` and cleared by `gie_clr`, one cycle later. The acknowledge takes priority over both.
- R11: An enable write (`ie_wr`) loads `ie_wdata` into the receive enable one cycle later, unless the software-reset bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up clear, asynchronous active low |
| swrst | input | 1 | Software-reset bit, level |
| master_mode | input | 1 | 1 when the port runs as master |
| char_rcvd | input | 1 | Character-complete strobe |
| rx_data | input | DATA_W | Received character |
| mst_ovr | input | 1 | Master-overrun strobe |
| buf_rd | input | 1 | Receive-buffer read pulse |
| rd_data | output | DATA_W | Receive-buffer contents |
| ie_wr | input | 1 | Write strobe for the receive enable |
| ie_wdata | input | 1 | Value written to the receive enable |
| gie_set | input | 1 | Software sets the global enable |
| gie_clr | input | 1 | Software clears the global enable |
| prio_ok | input | 1 | Priority arbitration grants this source |
| irq_ack | input | 1 | Processor has started servicing the request |
| irq_req | output | 1 | Registered interrupt request |
| flag | output | 1 | Sticky receive flag |
| ie | output | 1 | Receive interrupt enable |
| gie | output | 1 | Global interrupt enable |

## Verification
The properties take for granted that every input is a known value and changes only between clock edges of `clk`. They also assume the strobes mean one event per cycle in which they are high, since held strobes are treated as repeated events. They are disabled until the internal synchronized reset is released, which is why the bench keeps all inputs idle through the synchronizer cycles after `rst_n` rises. The random stimulus drives inputs on the falling edge from a fixed seed. It keeps the strobes sparse so that the flag spends long stretches pending with the gating inputs toggling. Directed sequences force the same-cycle set/clear collisions and a held software reset.

// File: rtl/rxif_pkg.sv
package rxif_pkg;
  localparam int unsigned RXIF_DATA_W = 8;
  localparam int unsigned RXIF_SYNC_STAGES = 2;

  typedef struct packed {
    logic set_ev;
    logic clr_ev;
    logic sw_rst;
  } flag_evt_t;
endpackage

// File: rtl/rxif_rst_sync.sv
module rxif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= 1'b0;
        end else begin
          if (s == 0) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxif_buffer.sv
module rxif_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] buf_q
);
  logic [DATA_W-1:0] buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load_en) buf_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end
endmodule

// File: rtl/rxif_flag.sv
module rxif_flag
  import rxif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_evt_t evt,
  output logic      flag_d,
  output logic      flag_q
);
  always_comb begin
    flag_d = flag_q;
    if (evt.sw_rst)      flag_d = 1'b0;
    else if (evt.set_ev) flag_d = 1'b1;
    else if (evt.clr_ev) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/rxif_enables.sv
module rxif_enables (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic ie_wr,
  input  logic ie_wdata,
  input  logic gie_set,
  input  logic gie_clr,
  input  logic svc_start,
  output logic ie_d,
  output logic gie_d,
  output logic ie_q,
  output logic gie_q
);
  always_comb begin
    ie_d = ie_q;
    if (sw_rst)     ie_d = 1'b0;
    else if (ie_wr) ie_d = ie_wdata;

    gie_d = gie_q;
    if (svc_start)    gie_d = 1'b0;
    else if (gie_set) gie_d = 1'b1;
    else if (gie_clr) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      gie_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      gie_q <= gie_d;
    end
  end
endmodule

// File: rtl/rxif_req.sv
module rxif_req (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_d,
  input  logic ie_d,
  input  logic gie_d,
  input  logic prio_ok,
  output logic req_q
);
  logic req_d;

  always_comb req_d = flag_d & ie_d & gie_d & prio_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/rx_irq_flag_ctrl.sv
module rx_irq_flag_ctrl
  import rxif_pkg::*;
#(
  parameter int unsigned DATA_W      = RXIF_DATA_W,
  parameter int unsigned SYNC_STAGES = RXIF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swrst,
  input  logic              master_mode,
  input  logic              char_rcvd,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              mst_ovr,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              prio_ok,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              flag,
  output logic              ie,
  output logic              gie
);
  logic      rst_sync_n;
  logic      load_en;
  flag_evt_t evt;
  logic      flag_d, ie_d, gie_d;

  rxif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    load_en    = char_rcvd & ~swrst;
    evt.sw_rst = swrst;
    evt.set_ev = char_rcvd | (mst_ovr & master_mode);
    evt.clr_ev = buf_rd | irq_ack;
  end

  rxif_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .load_en(load_en),
    .load_data(rx_data), .buf_q(rd_data)
  );

  rxif_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt),
    .flag_d(flag_d), .flag_q(flag)
  );

  rxif_enables u_en (
    .clk(clk), .rst_n(rst_sync_n), .sw_rst(swrst),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .svc_start(irq_ack),
    .ie_d(ie_d), .gie_d(gie_d), .ie_q(ie), .gie_q(gie)
  );

  rxif_req u_req (
    .clk(clk), .rst_n(rst_sync_n), .flag_d(flag_d), .ie_d(ie_d),
    .gie_d(gie_d), .prio_ok(prio_ok), .req_q(irq_req)
  );
endmodule

// File: rtl/rx_irq_flag_ctrl_chk.sv
module rx_irq_flag_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              swrst,
  input logic              master_mode,
  input logic              char_rcvd,
  input logic              mst_ovr,
  input logic              buf_rd,
  input logic              irq_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_req,
  input logic              flag,
  input logic              ie,
  input logic              gie
);
  logic set_any;
  assign set_any = char_rcvd | (mst_ovr & master_mode);

  assert_char_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (char_rcvd && !swrst) |=> flag);

  assert_ovr_sets_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mst_ovr && master_mode && !swrst) |=> flag);

  assert_ovr_keeps_buf_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!char_rcvd) |=> $stable(rd_data));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_rd && !set_any) |=> !flag);

  assert_ack_drops_gie_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_ack |=> !gie);

  assert_swrst_clears_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swrst |=> (!flag && !ie));

  assert_swrst_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swrst |=> $stable(rd_data));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_any && (buf_rd || irq_ack) && !swrst) |=> flag);

  assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> (flag && ie && gie));

  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!set_any && !buf_rd && !irq_ack && !swrst) |=> $stable(flag));
endmodule

bind rx_irq_flag_ctrl rx_irq_flag_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .swrst(swrst),
  .master_mode(master_mode), .char_rcvd(char_rcvd), .mst_ovr(mst_ovr),
  .buf_rd(buf_rd), .irq_ack(irq_ack), .rd_data(rd_data),
  .irq_req(irq_req), .flag(flag), .ie(ie), .gie(gie)
);

// File: tb/rx_irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module rx_irq_flag_ctrl_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic swrst, master_mode, char_rcvd, mst_ovr, buf_rd;
  logic [DW-1:0] rx_data, rd_data;
  logic ie_wr, ie_wdata, gie_set, gie_clr, prio_ok, irq_ack;
  logic irq_req, flag, ie, gie;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic m_flag, m_ie, m_gie, m_req;
  logic [DW-1:0] m_buf;

  always #4 clk = ~clk;

  rx_irq_flag_ctrl #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .swrst(swrst), .master_mode(master_mode),
    .char_rcvd(char_rcvd), .rx_data(rx_data), .mst_ovr(mst_ovr),
    .buf_rd(buf_rd), .rd_data(rd_data), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .prio_ok(prio_ok),
    .irq_ack(irq_ack), .irq_req(irq_req), .flag(flag), .ie(ie), .gie(gie)
  );

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string flag_tag();
    logic s;
    s = char_rcvd | (mst_ovr & master_mode);
    if (swrst) return "R6";
    if (s && (buf_rd || irq_ack)) return "R7";
    if (char_rcvd) return "R2";
    if (mst_ovr) return "R3";
    if (buf_rd) return "R4";
    if (irq_ack) return "R5";
    return "R9";
  endfunction

  task automatic idle();
    swrst = 0; char_rcvd = 0; mst_ovr = 0; buf_rd = 0;
    ie_wr = 0; ie_wdata = 0; gie_set = 0; gie_clr = 0; irq_ack = 0;
    rx_data = '0; prio_ok = 0;
  endtask

  // Inputs are already applied (after a falling edge); compute the model,
  // cross the rising edge, and compare at the next falling edge.
  task automatic step();
    logic n_flag, n_ie, n_gie;
    logic [DW-1:0] n_buf;
    string ft, it, gt;
    ft = flag_tag();
    it = (swrst) ? "R6" : "R11";
    gt = (irq_ack) ? "R5" : "R10";
    n_buf = (char_rcvd && !swrst) ? rx_data : m_buf;
    if (swrst) n_flag = 0;
    else if (char_rcvd || (mst_ovr && master_mode)) n_flag = 1;
    else if (buf_rd || irq_ack) n_flag = 0;
    else n_flag = m_flag;
    n_ie  = swrst ? 1'b0 : (ie_wr ? ie_wdata : m_ie);
    n_gie = irq_ack ? 1'b0 : (gie_set ? 1'b1 : (gie_clr ? 1'b0 : m_gie));
    m_req = n_flag & n_ie & n_gie & prio_ok;
    m_flag = n_flag; m_ie = n_ie; m_gie = n_gie; m_buf = n_buf;
    @(negedge clk);
    cyc++;
    chk(ft, "flag", {7'b0, flag}, {7'b0, m_flag});
    chk(it, "ie", {7'b0, ie}, {7'b0, m_ie});
    chk(gt, "gie", {7'b0, gie}, {7'b0, m_gie});
    chk("R8", "irq_req", {7'b0, irq_req}, {7'b0, m_req});
    chk((swrst) ? "R6" : "R2", "rd_data", rd_data, m_buf);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    idle(); master_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "flag", {7'b0, flag}, 8'h0);
    chk("R1", "ie", {7'b0, ie}, 8'h0);
    chk("R1", "gie", {7'b0, gie}, 8'h0);
    chk("R1", "irq_req", {7'b0, irq_req}, 8'h0);
    chk("R1", "rd_data", rd_data, 8'h0);
    m_flag = 0; m_ie = 0; m_gie = 0; m_req = 0; m_buf = '0;

    // Directed: enable everything, receive, request, acknowledge.
    ie_wr = 1; ie_wdata = 1; gie_set = 1; step(); idle();
    char_rcvd = 1; rx_data = 8'hA5; prio_ok = 1; step(); idle();
    prio_ok = 1; step();                      // R8 request raised
    irq_ack = 1; prio_ok = 1; step(); idle(); // R5 flag and gie cleared
    // Pending with gie off and low priority: R9
    char_rcvd = 1; rx_data = 8'h3C; step(); idle();
    prio_ok = 0; step(); step();
    // Set and read in same cycle: R7
    buf_rd = 1; char_rcvd = 1; rx_data = 8'h81; step(); idle();
    // Read alone: R4
    buf_rd = 1; step(); idle();
    // Overrun outside master mode ignored, then in master mode: R3
    mst_ovr = 1; master_mode = 0; step(); idle();
    mst_ovr = 1; master_mode = 1; irq_ack = 1; step(); idle();
    // Ack and gie_set together: ack wins (R10)
    gie_set = 1; irq_ack = 1; step(); idle();
    // Held software reset ignores strobes and writes: R6
    swrst = 1; char_rcvd = 1; rx_data = 8'hFF; ie_wr = 1; ie_wdata = 1; step();
    swrst = 1; mst_ovr = 1; char_rcvd = 1; rx_data = 8'h11; step(); idle();

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      master_mode = ($urandom_range(0, 3) != 0);
      char_rcvd   = ($urandom_range(0, 7) == 0);
      rx_data     = DW'($urandom);
      mst_ovr     = ($urandom_range(0, 15) == 0);
      buf_rd      = ($urandom_range(0, 9) == 0);
      irq_ack     = ($urandom_range(0, 11) == 0);
      swrst       = ($urandom_range(0, 40) == 0);
      ie_wr       = ($urandom_range(0, 12) == 0);
      ie_wdata    = ($urandom_range(0, 3) != 0);
      gie_set     = ($urandom_range(0, 6) == 0);
      gie_clr     = ($urandom_range(0, 14) == 0);
      prio_ok     = ($urandom_range(0, 2) != 0);
      step();
    end
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule